// File: doc/BRIEF.md
# I/O Page Table Translator

This block turns a 32-bit device-side I/O address into a 36-bit physical address by reading one page-table entry from memory for every request. There is no translation cache, so each request costs one table read. The page-table base and the start of the translation window come from a neighbouring register bank as plain inputs. A request carries the I/O address and a write flag. The response carries the physical address, the granted permission and a fault flag. On a fault the block also updates a captured status word and a captured fault address, and pulses an interrupt line.

Pages are 4 KB. The entry address is the base shifted left by four, plus four times the page number of the address after the window-start bits are masked away. An entry keeps physical page bits [35:12] in its upper 24 bits, a valid flag in bit 1 and a write-grant flag in bit 2. Bit 7 is a cacheable hint and bit 0 a write-as-zeros hint. Both hints are passed out with the response and do not change the translation. Only one request is in flight at a time. Both the request side and the response side use valid/ready handshakes, and so does the table read.

Top module: `iopt_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid, mem_req_valid and flt_irq are 0, flt_status is 0x00800000 and flt_addr is 0.
- R2: For each accepted request the block issues exactly one table read at mem_req_addr = base*16 + 4*((page & ~win) >> 12), computed in 36 bits, where page is the request address with bits [11:0] cleared. mem_req_addr stays stable while mem_req_ready is low.
- R3: The read data bus carries the byte at entry address + k in bits [8k+7:8k]. The entry is assembled big-endian, so the byte at offset 0 becomes entry bits [31:24].
- R4: A successful translation returns rsp_paddr = {entry[31:8], addr[11:0]}.
- R5: A successful translation sets rsp_rw to 1 (read-write) when entry bit 2 is 1, and to 0 (read-only) otherwise.
- R6: A fault is reported (rsp_fault=1) when entry bit 1 is 0, or when a write meets an entry whose bit 2 is 0. A faulting response has rsp_paddr = 0 and rsp_rw = 0.
- R7: On a fault, flt_status becomes 0xC0820000 for a write and 0xC0860000 for a read. Bit 23 of flt_status is always 1.
- R8: On a fault, flt_addr becomes the page address (bits [11:0] cleared). flt_status and flt_addr keep their values across later translations that do not fault.
- R9: flt_irq is high for exactly one cycle, the first cycle in which a faulting response is valid.
- R10: rsp_cache equals entry bit 7 and rsp_waz equals entry bit 0. Neither changes rsp_paddr or rsp_rw.
- R11: req_ready is 0 from the cycle after a request is accepted until the response has been taken. While rsp_valid is high and rsp_ready is low, the response holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base | input | 32 | Page-table base register value |
| win_start | input | 32 | Window start; set bits are masked off the page address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | I/O address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the table read |
| mem_req_addr | output | 36 | Entry address |
| mem_rsp_valid | input | 1 | Table read data valid |
| mem_rsp_data | input | 32 | Table read data, byte k in bits [8k+7:8k] |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | 36 | Physical address, zero on fault |
| rsp_rw | output | 1 | 1 read-write, 0 read-only |
| rsp_fault | output | 1 | Translation faulted |
| rsp_cache | output | 1 | Cacheable hint from the entry |
| rsp_waz | output | 1 | Write-as-zeros hint from the entry |
| flt_status | output | 32 | Captured fault status word |
| flt_addr | output | 32 | Captured faulting page address |
| flt_irq | output | 1 | One-cycle fault interrupt pulse |

## Verification
The hardest case to reach from the ports is keeping the captured fault state unchanged while good translations pass through. It needs a fault followed by successful lookups whose page addresses and entries differ from the faulting one. The vector walk places a good translation after each fault and tracks the expected captured words in the bench, so any overwrite shows up. The other hard case is the interrupt pulse under response backpressure. A directed fault test holds rsp_ready low for several cycles and checks that the pulse falls while the response stays steady.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int PTE_W = 32;
  localparam int BIT_VALID = 1;
  localparam int BIT_WRITE = 2;
  localparam int BIT_CACHE = 7;
  localparam int BIT_WAZ   = 0;
  localparam logic [31:0] ST_BASE = 32'hC082_0000;
  localparam logic [31:0] ST_READ = 32'h0004_0000;
  localparam logic [31:0] ST_RST  = 32'h0080_0000;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_RESP} xl_state_e;

  // lane k holds byte at offset k; offset 0 is most significant
  function automatic logic [PTE_W-1:0] be_word(input logic [PTE_W-1:0] lanes);
    logic [PTE_W-1:0] w;
    for (int k = 0; k < PTE_W/8; k++) w[PTE_W-1-8*k -: 8] = lanes[8*k +: 8];
    return w;
  endfunction

  function automatic logic [31:0] fault_word(input logic is_write);
    return is_write ? ST_BASE : (ST_BASE | ST_READ);
  endfunction
endpackage

// File: rtl/iopt_walk_addr.sv
module iopt_walk_addr #(
  parameter int VA_W = 32,
  parameter int EA_W = 36,
  parameter int PG_SH = 12,
  parameter int BASE_SH = 4
) (
  input  logic [VA_W-1:0] base,
  input  logic [VA_W-1:0] win,
  input  logic [VA_W-1:0] va,
  output logic [EA_W-1:0] ea
);
  localparam int PAD = EA_W - VA_W;

  function automatic logic [EA_W-1:0] entry_addr(input logic [VA_W-1:0] b,
      input logic [VA_W-1:0] w, input logic [VA_W-1:0] a);
    logic [VA_W-1:0] pg, idx;
    pg  = a & ~((VA_W)'((1 << PG_SH) - 1));
    idx = ((pg & ~w) >> (PG_SH - 2)) & ~(VA_W)'(3);
    return ({{PAD{1'b0}}, b} << BASE_SH) + {{PAD{1'b0}}, idx};
  endfunction

  assign ea = entry_addr(base, win, va);
endmodule

// File: rtl/iopt_pte_decode.sv
module iopt_pte_decode
  import iopt_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 36,
  parameter int PG_SH = 12
) (
  input  logic [PTE_W-1:0] entry,
  input  logic             is_write,
  input  logic [VA_W-1:0]  va,
  output logic             fault,
  output logic             rw,
  output logic [PA_W-1:0]  paddr,
  output logic             cache,
  output logic             waz,
  output logic [31:0]      status,
  output logic [VA_W-1:0]  page
);
  localparam int PPN_W = PA_W - PG_SH;

  logic unused_bits;
  assign unused_bits = ^entry[6:3];

  assign fault  = !entry[BIT_VALID] || (is_write && !entry[BIT_WRITE]);
  assign rw     = !fault && entry[BIT_WRITE];
  assign paddr  = fault ? '0 : {entry[PTE_W-1 -: PPN_W], va[PG_SH-1:0]};
  assign cache  = entry[BIT_CACHE];
  assign waz    = entry[BIT_WAZ];
  assign status = fault_word(is_write);
  assign page   = {va[VA_W-1:PG_SH], {PG_SH{1'b0}}};
endmodule

// File: rtl/iopt_seq.sv
module iopt_seq
  import iopt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_ready,
  output logic req_ready,
  output logic mem_req_valid,
  output logic rsp_valid,
  output logic acc_ev,
  output logic ld_ev
);
  xl_state_e st, st_n;

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_FETCH);
  assign rsp_valid     = (st == S_RESP);
  assign acc_ev        = req_valid && req_ready;
  assign ld_ev         = (st == S_WAIT) && mem_rsp_valid;

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:  if (acc_ev) st_n = S_FETCH;
      S_FETCH: if (mem_req_ready) st_n = S_WAIT;
      S_WAIT:  if (mem_rsp_valid) st_n = S_RESP;
      S_RESP:  if (rsp_ready) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_n;
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ev |=> !req_ready) else $error("one outstanding");  // R11
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ev |=> !mem_req_valid) else $error("single read");  // R2
endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
  import iopt_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 36,
  parameter int PG_SH = 12,
  parameter int BASE_SH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] tbl_base,
  input  logic [VA_W-1:0] win_start,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_addr,
  input  logic            req_write,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [31:0]     mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [PA_W-1:0] rsp_paddr,
  output logic            rsp_rw,
  output logic            rsp_fault,
  output logic            rsp_cache,
  output logic            rsp_waz,
  output logic [31:0]     flt_status,
  output logic [VA_W-1:0] flt_addr,
  output logic            flt_irq
);
  logic acc_ev, ld_ev;
  logic [VA_W-1:0] va_q;
  logic wr_q;
  logic [PA_W-1:0] ea_w;
  logic d_fault, d_rw, d_cache, d_waz;
  logic [PA_W-1:0] d_paddr;
  logic [31:0] d_status;
  logic [VA_W-1:0] d_page;

  iopt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .rsp_ready(rsp_ready), .req_ready(req_ready),
    .mem_req_valid(mem_req_valid), .rsp_valid(rsp_valid),
    .acc_ev(acc_ev), .ld_ev(ld_ev)
  );

  iopt_walk_addr #(.VA_W(VA_W), .EA_W(PA_W), .PG_SH(PG_SH), .BASE_SH(BASE_SH)) u_walk (
    .base(tbl_base), .win(win_start), .va(req_addr), .ea(ea_w)
  );

  iopt_pte_decode #(.VA_W(VA_W), .PA_W(PA_W), .PG_SH(PG_SH)) u_dec (
    .entry(be_word(mem_rsp_data)), .is_write(wr_q), .va(va_q),
    .fault(d_fault), .rw(d_rw), .paddr(d_paddr), .cache(d_cache),
    .waz(d_waz), .status(d_status), .page(d_page)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_q <= '0; wr_q <= 1'b0; mem_req_addr <= '0;
      rsp_paddr <= '0; rsp_rw <= 1'b0; rsp_fault <= 1'b0;
      rsp_cache <= 1'b0; rsp_waz <= 1'b0;
      flt_status <= ST_RST; flt_addr <= '0; flt_irq <= 1'b0;
    end else begin
      flt_irq <= 1'b0;
      if (acc_ev) begin
        va_q <= req_addr; wr_q <= req_write; mem_req_addr <= ea_w;
      end
      if (ld_ev) begin
        rsp_paddr <= d_paddr; rsp_rw <= d_rw; rsp_fault <= d_fault;
        rsp_cache <= d_cache; rsp_waz <= d_waz;
        if (d_fault) begin
          flt_status <= d_status; flt_addr <= d_page; flt_irq <= 1'b1;
        end
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))
    else $error("rsp hold");  // R11
  AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr))
    else $error("memreq hold");  // R2
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    flt_irq |=> !flt_irq) else $error("irq pulse");  // R9
  AST_IRQ_WITH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    flt_irq |-> rsp_valid && rsp_fault) else $error("irq fault");  // R9
  AST_FAULT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0 && !rsp_rw) else $error("fault grant");  // R6
  AST_STATUS_RESV: assert property (@(posedge clk) disable iff (!rst_n)
    flt_status[23]) else $error("status bit");  // R7
  AST_FLT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> $stable(flt_status) && $stable(flt_addr))
    else $error("fault keep");  // R8
endmodule

// File: tb/iopt_xlate_bench.sv
`timescale 1ns/1ps
module iopt_xlate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] tbl_base = '0, win_start = '0, req_addr = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic req_ready, mem_req_valid;
  logic mem_req_ready = 1'b1;
  logic [35:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic rsp_valid, rsp_rw, rsp_fault, rsp_cache, rsp_waz, flt_irq;
  logic rsp_ready = 1'b0;
  logic [35:0] rsp_paddr;
  logic [31:0] flt_status, flt_addr;

  always #4 clk = ~clk;

  iopt_xlate u_iopt_xlate (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .win_start(win_start),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_rw(rsp_rw), .rsp_fault(rsp_fault), .rsp_cache(rsp_cache),
    .rsp_waz(rsp_waz), .flt_status(flt_status), .flt_addr(flt_addr),
    .flt_irq(flt_irq)
  );

  int n_chk = 0, n_bad = 0, n_reads = 0;
  logic [31:0] cur_pte = '0;
  logic [35:0] seen_ea = '0;
  logic pend = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: responds the cycle after the read is accepted, little lane order
  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    else if (pend) begin
      for (int k = 0; k < 4; k++) mem_rsp_data[8*k +: 8] = cur_pte[31-8*k -: 8];
      mem_rsp_valid = 1'b1;
      pend = 1'b0;
    end
    if (mem_req_valid && mem_req_ready) begin
      seen_ea = mem_req_addr; pend = 1'b1; n_reads++;
    end
  end

  // base, window, address, write, entry
  localparam logic [159:0] VEC [8] = '{
    {32'h0000_0400, 32'hFF00_0000, 32'hFF00_1234, 32'd0, 32'h1234_5606},
    {32'h0000_0400, 32'hFF00_0000, 32'hFF05_3FFF, 32'd1, 32'h00AB_C002},
    {32'h0000_0800, 32'hFE00_0000, 32'hFFFF_F001, 32'd0, 32'h00AB_C002},
    {32'h0000_0800, 32'hFE00_0000, 32'hFE00_0ABC, 32'd0, 32'hDEAD_BE04},
    {32'h0123_4400, 32'hF000_0000, 32'hF123_4567, 32'd1, 32'hFFFF_FF87},
    {32'h0000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 32'h0000_1002},
    {32'h07FF_FC00, 32'h0000_0000, 32'h0000_3ABC, 32'd1, 32'h0000_0004},
    {32'h07FF_FC00, 32'h0000_0000, 32'h0010_0FFF, 32'd1, 32'h8765_4306}
  };

  logic [31:0] exp_st = 32'h0080_0000, exp_fa = '0;

  task automatic xlate(input logic [31:0] b, input logic [31:0] w, input logic [31:0] a,
                       input logic wr, input logic [31:0] pte, input int hold);
    logic [31:0] pg;
    logic [35:0] e_ea, e_pa;
    logic ok;
    int guard;
    pg   = a & 32'hFFFF_F000;
    e_ea = 36'(b) * 36'd16 + 36'((pg & ~w) >> 12) * 36'd4;
    ok   = pte[1] && (!wr || pte[2]);
    e_pa = ok ? {pte[31:8], 12'h000} + 36'(a[11:0]) : 36'd0;
    if (!ok) begin
      exp_st = wr ? 32'hC082_0000 : 32'hC086_0000;
      exp_fa = pg;
    end
    tbl_base = b; win_start = w; req_addr = a; req_write = wr; cur_pte = pte;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 busy req_ready", 64'(req_ready), 64'd0);
    guard = 0;
    while (!rsp_valid && guard < 50) begin @(negedge clk); guard++; end
    check("R2 entry address", 64'(seen_ea), 64'(e_ea));
    check("R4 R3 paddr", 64'(rsp_paddr), 64'(e_pa));
    check("R5 permission", 64'(rsp_rw), 64'(ok && pte[2]));
    check("R6 fault", 64'(rsp_fault), 64'(!ok));
    check("R10 hints", 64'({rsp_cache, rsp_waz}), 64'({pte[7], pte[0]}));
    check("R9 irq first cycle", 64'(flt_irq), 64'(!ok));
    check("R7 status", 64'(flt_status), 64'(exp_st));
    check("R8 fault addr", 64'(flt_addr), 64'(exp_fa));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check("R11 held valid", 64'(rsp_valid), 64'd1);
      check("R11 held paddr", 64'(rsp_paddr), 64'(e_pa));
      check("R9 irq dropped", 64'(flt_irq), 64'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R11 ready again", 64'(req_ready), 64'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 idle outputs", 64'({rsp_valid, mem_req_valid, flt_irq}), 64'd0);
    check("R1 status", 64'(flt_status), 64'h0080_0000);
    check("R1 fault addr", 64'(flt_addr), 64'd0);

    for (int i = 0; i < 8; i++) begin
      logic [159:0] v;
      v = VEC[i];
      xlate(v[159:128], v[127:96], v[95:64], v[32], v[31:0], 0);
    end
    check("R2 one read per request", 64'(n_reads), 64'd8);

    // fault under backpressure, then good translations must keep captured state
    xlate(32'h0000_1000, 32'hFF00_0000, 32'hFF7F_E123, 1'b0, 32'h0000_0000, 3);
    xlate(32'h0000_1000, 32'hFF00_0000, 32'hFF00_2000, 1'b1, 32'h4444_4486, 2);
    // hints on an otherwise plain read-only entry do not alter paddr
    xlate(32'h0000_1000, 32'hFF00_0000, 32'hFF00_2FFF, 1'b0, 32'h4444_4483, 0);

    // memory stall: read address must stay until accepted
    mem_req_ready = 1'b0;
    tbl_base = 32'h0000_2000; win_start = 32'hFF00_0000;
    req_addr = 32'hFF00_5000; req_write = 1'b0; cur_pte = 32'h0000_0102;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    tbl_base = 32'h0;
    repeat (3) @(negedge clk);
    check("R2 stalled read addr", 64'(mem_req_addr), 64'h0_0002_0014);
    check("R2 stalled read valid", 64'(mem_req_valid), 64'd1);
    mem_req_ready = 1'b1;
    while (!rsp_valid) @(negedge clk);
    check("R4 after stall", 64'(rsp_paddr), 64'h0_0000_1000);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule